// File: doc/BRIEF.md
# Pointer-Pair Register File

This block is the working register file of a small 8-bit processor core. It stores thirty-two 8-bit registers and serves two operand read ports and one operand write port, so an instruction can read two sources and write one result in every clock cycle. The same registers also appear in data space: addresses 0 through 31 map one-to-one onto the registers, and any wider address misses the file.

The six highest registers pair up into three 16-bit pointers. A pointer port picks one pair and a mode. It then either produces the pointer plus a small unsigned offset, or produces an address and writes back the incremented or decremented pointer, both bytes in the same edge. A bypass input lets the read ports return the value that the coming edge will store in place of the current contents. The core's load/store unit uses the pointer port for indirect addressing.

Top module: `gpr_ptr_file`

## Requirements
- R1: Reset (rst_n low) clears all 32 registers to zero. While reset is held and after it is released, every read returns 0x00 until a write occurs.
- R2: Each operand read port returns, combinationally, the current contents of the register its 5-bit index selects. The two ports are independent and cover indices 0 to 31.
- R3: With wr_en high, wr_data is stored into register wr_idx on the rising clock edge and is visible on the read ports from then on.
- R4: With byp_en low, a read of a register that is written in the same cycle returns the old contents. With byp_en high, the operand ports and the data-space read port return the value that the next edge will store, after all write priorities are applied.
- R5: A data-space address n below 32 selects register n for both reads and writes (ds_we), and ds_hit is 1. An address of 32 or above gives ds_hit = 0 and ds_rdata = 0x00, and a write to it changes no register, even when its low five bits match a register.
- R6: ptr_sel 0 selects X = {R27,R26}, 1 selects Y = {R29,R28}, and 2 selects Z = {R31,R30}. In each pair the odd register is the high byte. ptr_sel 3 selects nothing: ptr_addr is 0x0000 and no register changes.
- R7: ptr_mode 0 (offset) gives ptr_addr = pointer + zero-extended 6-bit ptr_disp, modulo 2^16, for Y and Z. For X the offset is ignored. The pointer is never written back in this mode.
- R8: ptr_mode 1 (post-increment) with ptr_en high gives ptr_addr = the old pointer and stores pointer + 1 at the edge. 0xFFFF wraps to 0x0000.
- R9: ptr_mode 2 (pre-decrement) with ptr_en high gives ptr_addr = pointer - 1 and stores that same value at the edge. 0x0000 wraps to 0xFFFF.
- R10: ptr_mode 3 (plain) gives ptr_addr = the pointer and writes nothing back, whether or not ptr_en is high.
- R11: When several writes hit one register at the same edge, the pointer update wins over the operand write, and the operand write wins over the data-space write. Writes to different registers all land at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| byp_en | input | 1 | Read ports return next-edge values when high |
| rd_a_idx | input | 5 | Operand read port A register index |
| rd_a_data | output | 8 | Operand read port A data |
| rd_b_idx | input | 5 | Operand read port B register index |
| rd_b_data | output | 8 | Operand read port B data |
| wr_en | input | 1 | Operand write enable |
| wr_idx | input | 5 | Operand write register index |
| wr_data | input | 8 | Operand write data |
| ds_addr | input | 16 | Data-space address |
| ds_we | input | 1 | Data-space write enable |
| ds_wdata | input | 8 | Data-space write data |
| ds_rdata | output | 8 | Data-space read data, zero on a miss |
| ds_hit | output | 1 | Address falls inside the register file |
| ptr_en | input | 1 | Allow pointer write-back this cycle |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 none |
| ptr_mode | input | 2 | 0 offset, 1 post-increment, 2 pre-decrement, 3 plain |
| ptr_disp | input | 6 | Unsigned offset for mode 0 |
| ptr_addr | output | 16 | Effective address from the selected pointer |

## Verification
Three write sources can hit the same register at one edge: a pointer write-back, an operand write and a data-space write. The bench provokes this in one cycle by running a post-increment of X while the operand port targets X's low byte and the data-space port targets X's high byte. It then repeats the clash with only the operand and data-space ports. In the same cycle it reads the register through the bypass path, and it reads the pair back after the edge, to confirm that each register holds the winner under R11. A further case sends the two lower-priority writes to different registers and confirms that both land.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned GPR_COUNT = 32;
  localparam int unsigned GPR_IDX_W = $clog2(GPR_COUNT);
  localparam int unsigned PTR_BASE  = 26;

  typedef enum logic [1:0] {
    PTR_X    = 2'd0,
    PTR_Y    = 2'd1,
    PTR_Z    = 2'd2,
    PTR_NONE = 2'd3
  } ptr_sel_e;

  typedef enum logic [1:0] {
    PM_DISP    = 2'd0,
    PM_POSTINC = 2'd1,
    PM_PREDEC  = 2'd2,
    PM_PLAIN   = 2'd3
  } ptr_mode_e;

  // Index of the low byte of a pointer pair; the high byte sits one above.
  function automatic logic [GPR_IDX_W-1:0] ptr_lo_idx(input ptr_sel_e s);
    return GPR_IDX_W'(PTR_BASE + 2 * int'(s));
  endfunction

  function automatic logic mode_writes_back(input ptr_mode_e m);
    return (m == PM_POSTINC) || (m == PM_PREDEC);
  endfunction
endpackage

// File: rtl/gpr_ptr_unit.sv
module gpr_ptr_unit
  import gpr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DISP_W = 6,
  localparam int unsigned PTR_W = 2 * DATA_W
) (
  input  logic [GPR_COUNT-1:0][DATA_W-1:0] regs_q,
  input  logic                             ptr_en,
  input  ptr_sel_e                         sel,
  input  ptr_mode_e                        mode,
  input  logic [DISP_W-1:0]                disp,
  output logic [PTR_W-1:0]                 ptr_cur,
  output logic [PTR_W-1:0]                 ptr_addr,
  output logic                             upd_en,
  output logic [GPR_IDX_W-1:0]             upd_lo_idx,
  output logic [PTR_W-1:0]                 upd_val
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  function automatic logic [PTR_W-1:0] eff_addr(input ptr_sel_e s, input ptr_mode_e m,
                                                input logic [PTR_W-1:0] cur,
                                                input logic [DISP_W-1:0] d);
    logic [PTR_W-1:0] off;
    off = (s == PTR_X) ? '0 : PTR_W'(d);
    case (m)
      PM_DISP:   return cur + off;
      PM_PREDEC: return cur - ONE;
      default:   return cur;
    endcase
  endfunction

  function automatic logic [PTR_W-1:0] next_ptr(input ptr_mode_e m, input logic [PTR_W-1:0] cur);
    case (m)
      PM_POSTINC: return cur + ONE;
      PM_PREDEC:  return cur - ONE;
      default:    return cur;
    endcase
  endfunction

  logic                 sel_ok;
  logic [GPR_IDX_W-1:0] lo_idx;
  logic [GPR_IDX_W-1:0] hi_idx;

  assign sel_ok     = (sel != PTR_NONE);
  assign lo_idx     = ptr_lo_idx(sel);
  assign hi_idx     = lo_idx + GPR_IDX_W'(1);
  assign ptr_cur    = sel_ok ? {regs_q[hi_idx], regs_q[lo_idx]} : '0;
  assign ptr_addr   = sel_ok ? eff_addr(sel, mode, ptr_cur, disp) : '0;
  assign upd_en     = ptr_en && sel_ok && mode_writes_back(mode);
  assign upd_lo_idx = lo_idx;
  assign upd_val    = next_ptr(mode, ptr_cur);
endmodule

// File: rtl/gpr_write_merge.sv
module gpr_write_merge
  import gpr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = 2 * DATA_W
) (
  input  logic [GPR_COUNT-1:0][DATA_W-1:0] regs_q,
  input  logic                             upd_en,
  input  logic [GPR_IDX_W-1:0]             upd_lo_idx,
  input  logic [PTR_W-1:0]                 upd_val,
  input  logic                             wr_en,
  input  logic [GPR_IDX_W-1:0]             wr_idx,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             ds_we,
  input  logic [GPR_IDX_W-1:0]             ds_idx,
  input  logic [DATA_W-1:0]                ds_wdata,
  output logic [GPR_COUNT-1:0][DATA_W-1:0] regs_d,
  output logic                             ptr_wr_clash
);
  logic [GPR_IDX_W-1:0] upd_hi_idx;
  assign upd_hi_idx   = upd_lo_idx + GPR_IDX_W'(1);
  assign ptr_wr_clash = upd_en && wr_en && ((wr_idx == upd_lo_idx) || (wr_idx == upd_hi_idx));

  // Later assignments override earlier ones: data space < operand < pointer.
  for (genvar i = 0; i < GPR_COUNT; i++) begin : g_reg
    always_comb begin
      regs_d[i] = regs_q[i];
      if (ds_we && (ds_idx == GPR_IDX_W'(i)))
        regs_d[i] = ds_wdata;
      if (wr_en && (wr_idx == GPR_IDX_W'(i)))
        regs_d[i] = wr_data;
      if (upd_en && (upd_lo_idx == GPR_IDX_W'(i)))
        regs_d[i] = upd_val[DATA_W-1:0];
      if (upd_en && (upd_hi_idx == GPR_IDX_W'(i)))
        regs_d[i] = upd_val[PTR_W-1:DATA_W];
    end
  end
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
  import gpr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [GPR_COUNT-1:0][DATA_W-1:0] regs_q,
  input  logic [GPR_COUNT-1:0][DATA_W-1:0] regs_d,
  input  logic                             byp_en,
  input  logic [GPR_IDX_W-1:0]             idx,
  output logic [DATA_W-1:0]                data
);
  assign data = byp_en ? regs_d[idx] : regs_q[idx];
endmodule

// File: rtl/gpr_ptr_file.sv
module gpr_ptr_file
  import gpr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DISP_W = 6,
  parameter int unsigned DS_AW  = 16,
  localparam int unsigned PTR_W = 2 * DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 byp_en,
  input  logic [GPR_IDX_W-1:0] rd_a_idx,
  output logic [DATA_W-1:0]    rd_a_data,
  input  logic [GPR_IDX_W-1:0] rd_b_idx,
  output logic [DATA_W-1:0]    rd_b_data,
  input  logic                 wr_en,
  input  logic [GPR_IDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [DS_AW-1:0]     ds_addr,
  input  logic                 ds_we,
  input  logic [DATA_W-1:0]    ds_wdata,
  output logic [DATA_W-1:0]    ds_rdata,
  output logic                 ds_hit,
  input  logic                 ptr_en,
  input  logic [1:0]           ptr_sel,
  input  logic [1:0]           ptr_mode,
  input  logic [DISP_W-1:0]    ptr_disp,
  output logic [PTR_W-1:0]     ptr_addr
);
  logic [GPR_COUNT-1:0][DATA_W-1:0] regs_q;
  logic [GPR_COUNT-1:0][DATA_W-1:0] regs_d;
  logic [PTR_W-1:0]                 ptr_cur_w;
  logic                             upd_en_w;
  logic [GPR_IDX_W-1:0]             upd_lo_idx_w;
  logic [PTR_W-1:0]                 upd_val_w;
  logic                             ptr_wr_clash_w;
  logic [GPR_IDX_W-1:0]             ds_idx_w;
  logic [DATA_W-1:0]                ds_raw_w;

  assign ds_hit   = (ds_addr[DS_AW-1:GPR_IDX_W] == '0);
  assign ds_idx_w = ds_addr[GPR_IDX_W-1:0];
  assign ds_rdata = ds_hit ? ds_raw_w : '0;

  gpr_ptr_unit #(.DATA_W(DATA_W), .DISP_W(DISP_W)) u_ptr (
    .regs_q     (regs_q),
    .ptr_en     (ptr_en),
    .sel        (ptr_sel_e'(ptr_sel)),
    .mode       (ptr_mode_e'(ptr_mode)),
    .disp       (ptr_disp),
    .ptr_cur    (ptr_cur_w),
    .ptr_addr   (ptr_addr),
    .upd_en     (upd_en_w),
    .upd_lo_idx (upd_lo_idx_w),
    .upd_val    (upd_val_w)
  );

  gpr_write_merge #(.DATA_W(DATA_W)) u_merge (
    .regs_q       (regs_q),
    .upd_en       (upd_en_w),
    .upd_lo_idx   (upd_lo_idx_w),
    .upd_val      (upd_val_w),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_data      (wr_data),
    .ds_we        (ds_we && ds_hit),
    .ds_idx       (ds_idx_w),
    .ds_wdata     (ds_wdata),
    .regs_d       (regs_d),
    .ptr_wr_clash (ptr_wr_clash_w)
  );

  gpr_read_port #(.DATA_W(DATA_W)) u_rd_a (
    .regs_q (regs_q), .regs_d (regs_d), .byp_en (byp_en), .idx (rd_a_idx), .data (rd_a_data)
  );
  gpr_read_port #(.DATA_W(DATA_W)) u_rd_b (
    .regs_q (regs_q), .regs_d (regs_d), .byp_en (byp_en), .idx (rd_b_idx), .data (rd_b_data)
  );
  gpr_read_port #(.DATA_W(DATA_W)) u_rd_ds (
    .regs_q (regs_q), .regs_d (regs_d), .byp_en (byp_en), .idx (ds_idx_w), .data (ds_raw_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) regs_q <= '0;
    else        regs_q <= regs_d;
  end
endmodule

// File: rtl/gpr_ptr_file_chk.sv
module gpr_ptr_file_chk
  import gpr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DISP_W = 6,
  localparam int unsigned PTR_W = 2 * DATA_W
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [GPR_COUNT-1:0][DATA_W-1:0] regs_q,
  input logic                             ptr_en,
  input logic [1:0]                       ptr_sel,
  input logic [1:0]                       ptr_mode,
  input logic [DISP_W-1:0]                ptr_disp,
  input logic [PTR_W-1:0]                 ptr_addr,
  input logic [PTR_W-1:0]                 ptr_cur,
  input logic                             upd_en,
  input logic [GPR_IDX_W-1:0]             upd_lo_idx,
  input logic                             ptr_wr_clash,
  input logic                             wr_en,
  input logic [GPR_IDX_W-1:0]             wr_idx,
  input logic [DATA_W-1:0]                wr_data,
  input logic                             ds_hit,
  input logic [DATA_W-1:0]                ds_rdata
);
  assert_wr_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ptr_wr_clash) |=> (regs_q[$past(wr_idx)] == $past(wr_data)));

  assert_miss_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ds_hit |-> (ds_rdata == '0));

  assert_none_sel_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_sel == 2'd3) |-> (ptr_addr == '0 && !upd_en));

  assert_disp_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_mode == 2'd0 && (ptr_sel == 2'd1 || ptr_sel == 2'd2))
      |-> (ptr_addr == PTR_W'(ptr_cur + PTR_W'(ptr_disp))));

  assert_postinc_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_en && ptr_mode == 2'd1 && ptr_sel != 2'd3)
      |=> ({regs_q[GPR_IDX_W'($past(upd_lo_idx) + 1'b1)], regs_q[$past(upd_lo_idx)]}
           == PTR_W'($past(ptr_cur) + 1'b1)));

  assert_predec_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_mode == 2'd2 && ptr_sel != 2'd3) |-> (ptr_addr == PTR_W'(ptr_cur - 1'b1)));

  assert_predec_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_en && ptr_mode == 2'd2 && ptr_sel != 2'd3)
      |=> ({regs_q[GPR_IDX_W'($past(upd_lo_idx) + 1'b1)], regs_q[$past(upd_lo_idx)]}
           == $past(ptr_addr)));

  assert_no_writeback_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_mode == 2'd0 || ptr_mode == 2'd3) |-> !upd_en);

  assert_ptr_beats_operand_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && ptr_mode == 2'd1 && wr_en && wr_idx == upd_lo_idx)
      |=> (regs_q[$past(upd_lo_idx)] == DATA_W'($past(ptr_cur) + 1'b1)));
endmodule

bind gpr_ptr_file gpr_ptr_file_chk #(.DATA_W(DATA_W), .DISP_W(DISP_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .regs_q       (regs_q),
  .ptr_en       (ptr_en),
  .ptr_sel      (ptr_sel),
  .ptr_mode     (ptr_mode),
  .ptr_disp     (ptr_disp),
  .ptr_addr     (ptr_addr),
  .ptr_cur      (ptr_cur_w),
  .upd_en       (upd_en_w),
  .upd_lo_idx   (upd_lo_idx_w),
  .ptr_wr_clash (ptr_wr_clash_w),
  .wr_en        (wr_en),
  .wr_idx       (wr_idx),
  .wr_data      (wr_data),
  .ds_hit       (ds_hit),
  .ds_rdata     (ds_rdata)
);

// File: tb/gpr_ptr_file_bench.sv
`timescale 1ns/1ps
module gpr_ptr_file_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        byp_en;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [7:0]  rd_a_data, rd_b_data, wr_data, ds_wdata, ds_rdata;
  logic        wr_en, ds_we, ds_hit, ptr_en;
  logic [15:0] ds_addr, ptr_addr;
  logic [1:0]  ptr_sel, ptr_mode;
  logic [5:0]  ptr_disp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] model [32];

  always #4 clk = ~clk;

  gpr_ptr_file u_gpr_ptr_file (.*);

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic idle();
    byp_en = 0; wr_en = 0; wr_idx = 0; wr_data = 0;
    ds_we = 0; ds_addr = 16'hFFFF; ds_wdata = 0;
    ptr_en = 0; ptr_sel = 2'd3; ptr_mode = 2'd3; ptr_disp = 0;
    rd_a_idx = 0; rd_b_idx = 0;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr(input int idx, input logic [7:0] val);
    wr_en = 1; wr_idx = 5'(idx); wr_data = val;
    tick();
    wr_en = 0;
    model[idx] = val;
  endtask

  task automatic reg_chk(input string req, input int idx, input logic [7:0] exp);
    rd_a_idx = 5'(idx); rd_b_idx = 5'(idx); #0.5;
    chk(req, $sformatf("port A reg %0d", idx), {24'h0, rd_a_data}, {24'h0, exp});
    chk(req, $sformatf("port B reg %0d", idx), {24'h0, rd_b_data}, {24'h0, exp});
  endtask

  task automatic t_reset();
    rst_n = 0; idle();
    repeat (3) @(posedge clk); #2;
    rd_a_idx = 5'd7; rd_b_idx = 5'd31; #0.5;
    chk("R1", "in reset A", {24'h0, rd_a_data}, 32'h0);
    chk("R1", "in reset B", {24'h0, rd_b_data}, 32'h0);
    rst_n = 1; tick();
    for (int i = 0; i < 32; i++) begin
      rd_a_idx = 5'(i); #0.1;
      chk("R1", $sformatf("after reset reg %0d", i), {24'h0, rd_a_data}, 32'h0);
      model[i] = 8'h00;
    end
  endtask

  task automatic t_write_read();
    for (int i = 0; i < 32; i++) wr(i, 8'(i * 29 + 7));
    for (int i = 0; i < 32; i++) begin
      rd_a_idx = 5'(i); rd_b_idx = 5'(31 - i); #0.1;
      chk("R2", $sformatf("port A reg %0d", i), {24'h0, rd_a_data}, {24'h0, model[i]});
      chk("R3", $sformatf("port B reg %0d", 31 - i), {24'h0, rd_b_data}, {24'h0, model[31 - i]});
    end
  endtask

  task automatic t_bypass();
    wr_en = 1; wr_idx = 5'd5; wr_data = 8'h5A;
    rd_a_idx = 5'd5; rd_b_idx = 5'd5; ds_addr = 16'd5; byp_en = 0; #0.5;
    chk("R4", "no bypass old value", {24'h0, rd_a_data}, {24'h0, model[5]});
    byp_en = 1; #0.5;
    chk("R4", "bypass port B new value", {24'h0, rd_b_data}, 32'h5A);
    chk("R4", "bypass data-space new value", {24'h0, ds_rdata}, 32'h5A);
    tick();
    wr_en = 0; byp_en = 0; model[5] = 8'h5A;
    reg_chk("R3", 5, 8'h5A);
  endtask

  task automatic t_dataspace();
    ds_addr = 16'd10; ds_we = 1; ds_wdata = 8'hC3;
    tick();
    ds_we = 0; model[10] = 8'hC3;
    reg_chk("R5", 10, 8'hC3);
    ds_addr = 16'd31; #0.5;
    chk("R5", "hit at 31", {31'h0, ds_hit}, 32'h1);
    chk("R5", "read at 31", {24'h0, ds_rdata}, {24'h0, model[31]});
    ds_addr = 16'd32; #0.5;
    chk("R5", "miss at 32", {31'h0, ds_hit}, 32'h0);
    chk("R5", "zero data at 32", {24'h0, ds_rdata}, 32'h0);
    ds_addr = 16'h002A; ds_we = 1; ds_wdata = 8'h77;
    tick();
    ds_we = 0;
    reg_chk("R5", 10, 8'hC3);
    ds_addr = 16'h100A; ds_we = 1; ds_wdata = 8'h66;
    tick();
    ds_we = 0;
    reg_chk("R5", 10, 8'hC3);
  endtask

  task automatic t_ptr_read();
    wr(26, 8'h34); wr(27, 8'h12); wr(28, 8'hFF); wr(29, 8'hFF); wr(30, 8'h00); wr(31, 8'h00);
    ptr_sel = 2'd0; ptr_mode = 2'd0; ptr_disp = 6'd5; #0.5;
    chk("R7", "X ignores offset", {16'h0, ptr_addr}, 32'h1234);
    ptr_sel = 2'd1; ptr_disp = 6'd63; #0.5;
    chk("R7", "Y plus 63 wraps", {16'h0, ptr_addr}, 32'h003E);
    ptr_sel = 2'd2; ptr_disp = 6'h21; #0.5;
    chk("R7", "Z plus 0x21", {16'h0, ptr_addr}, 32'h0021);
    ptr_mode = 2'd3; #0.5;
    chk("R10", "Z plain", {16'h0, ptr_addr}, 32'h0000);
    ptr_sel = 2'd3; ptr_mode = 2'd1; ptr_en = 1; #0.5;
    chk("R6", "no pointer selected", {16'h0, ptr_addr}, 32'h0000);
    tick();
    ptr_sel = 2'd1; ptr_mode = 2'd0; ptr_disp = 6'd9;
    tick();
    ptr_en = 0; ptr_sel = 2'd3;
    reg_chk("R7", 28, 8'hFF);
    reg_chk("R6", 26, 8'h34);
  endtask

  task automatic t_postinc();
    ptr_en = 1; ptr_sel = 2'd1; ptr_mode = 2'd1; #0.5;
    chk("R8", "Y returns old", {16'h0, ptr_addr}, 32'hFFFF);
    tick();
    ptr_en = 0;
    reg_chk("R8", 28, 8'h00);
    reg_chk("R8", 29, 8'h00);
    ptr_en = 1; ptr_sel = 2'd0; #0.5;
    chk("R8", "X returns old", {16'h0, ptr_addr}, 32'h1234);
    tick();
    ptr_en = 0; #0.5;
    chk("R8", "X advanced", {16'h0, ptr_addr}, 32'h1235);
    model[26] = 8'h35; model[28] = 8'h00; model[29] = 8'h00;
    ptr_sel = 2'd3;
  endtask

  task automatic t_predec();
    ptr_en = 1; ptr_sel = 2'd2; ptr_mode = 2'd2; #0.5;
    chk("R9", "Z 0000 minus one", {16'h0, ptr_addr}, 32'hFFFF);
    tick();
    #0.5;
    chk("R9", "Z next predec", {16'h0, ptr_addr}, 32'hFFFE);
    tick();
    ptr_en = 0;
    reg_chk("R9", 30, 8'hFE);
    reg_chk("R9", 31, 8'hFF);
    ptr_en = 1; ptr_sel = 2'd0; ptr_mode = 2'd3;
    tick();
    ptr_en = 0;
    reg_chk("R10", 26, 8'h35);
    ptr_sel = 2'd3;
  endtask

  task automatic t_priority();
    ptr_en = 1; ptr_sel = 2'd0; ptr_mode = 2'd1;
    wr_en = 1; wr_idx = 5'd26; wr_data = 8'hAA;
    ds_we = 1; ds_addr = 16'd27; ds_wdata = 8'hBB;
    byp_en = 1; rd_a_idx = 5'd26; rd_b_idx = 5'd27; #0.5;
    chk("R11", "bypass shows pointer low", {24'h0, rd_a_data}, 32'h36);
    chk("R11", "bypass shows pointer high", {24'h0, rd_b_data}, 32'h12);
    tick();
    ptr_en = 0; ptr_sel = 2'd3; byp_en = 0;
    reg_chk("R11", 26, 8'h36);
    reg_chk("R11", 27, 8'h12);
    wr_idx = 5'd26; wr_data = 8'h11; ds_addr = 16'd26; ds_wdata = 8'h22;
    tick();
    reg_chk("R11", 26, 8'h11);
    wr_idx = 5'd5; wr_data = 8'h44; ds_addr = 16'd27; ds_wdata = 8'h33;
    tick();
    wr_en = 0; ds_we = 0;
    reg_chk("R11", 5, 8'h44);
    reg_chk("R11", 27, 8'h33);
  endtask

  task automatic t_reset_again();
    rst_n = 0; tick(); rst_n = 1;
    reg_chk("R1", 5, 8'h00);
    reg_chk("R1", 27, 8'h00);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog all requirements actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_write_read();
    t_bypass();
    t_dataspace();
    t_ptr_read();
    t_postinc();
    t_predec();
    t_priority();
    t_reset_again();
    if (!done) begin
      done = 1'b1;
      finish_run();
    end
  end
endmodule